// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device-side end of a two-wire serial management link. It runs on the management clock supplied by the station and treats the bidirectional data line as three separate signals: a sampled input, a data output and an output enable. It finds frame alignment from a run of ones followed by a start pattern. It then decodes the opcode, the device address and the register address, and either returns a 16-bit register value or stores one into a small register file.

Frames for another device address, and frames with an unused opcode, are tracked to their end without driving the line. After such a frame the block hunts for the next preamble. Register addresses beyond the implemented range read back as all ones, and writes to them have no effect. A new frame may start on the bit right after the last data bit of the previous frame.

Top module: `mdio_slave`

## Requirements
- R1: A frame is recognised only after at least PRE_MIN (default 32) consecutive ones sampled on `mdio_i`, then the start bits 0 and 1. With fewer ones the frame is ignored: nothing is driven and nothing is written.
- R2: After the start bits, the two opcode bits are read first-bit-first. The value 2'b10 is a read and 2'b01 is a write. Frames with 2'b00 or 2'b11 neither drive the line nor change any register.
- R3: A 5-bit device address and then a 5-bit register address follow the opcode, each MSB first. If the device address differs from `phy_addr_i`, the frame neither drives the line nor changes any register.
- R4: On a read, `mdio_oe` stays low during the first turnaround bit period. During the second turnaround bit period it is high with `mdio_o` low.
- R5: On a read, the 16 data bits are presented MSB first, one per bit period, starting in the period after the second turnaround bit. Each bit changes just after a rising edge of `mdc`, so it is stable at the station's next rising-edge sample.
- R6: On a write, the 16 data bits are sampled MSB first and stored at the end of the frame. The store happens only if the two turnaround bits were 1 then 0.
- R7: A read of a register address at or above NUM_REGS (default 8) returns 16'hFFFF.
- R8: A write to a register address at or above NUM_REGS leaves every implemented register unchanged.
- R9: `mdio_oe` is high only during the second turnaround bit and the data bits of a read addressed to this device. In the bit period after the last data bit it is low again.
- R10: A frame whose preamble starts on the bit right after the last data bit of the previous frame is served normally. No idle bit is needed between frames.
- R11: `rst` is synchronous and active high. It clears `mdio_oe` and `mdio_o`, and sets register n to 16'hC300 + n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr_i | input | 5 | Device address this slave answers to |
| mdio_i | input | 1 | Sampled level of the management data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line; low means high impedance |

## Verification
On every cycle, the assertions check where `mdio_oe` may be high. They check that the first turnaround bit is never driven, that the second one is driven low, and that the enable is tied to a decoded read for this device. They also check that a store never targets an unimplemented address and that the line is released right after the last data bit. Whether the right data comes back in MSB order, and whether writes with a bad turnaround, a foreign address, an unused opcode or a short preamble leave the registers untouched, can only be seen through the bench's frame sequences. The bench confirms these by reading the registers back. Back-to-back operation is covered the same way, since the bench sends every frame with no idle gap.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int HDR_BITS = 2 + 2 * ADDR_W;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_HDR,
    ST_TA,
    ST_DATA
  } mdio_state_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              hit;
    logic [ADDR_W-1:0] reg_addr;
  } mdio_req_t;

  function automatic logic [DATA_W-1:0] reg_reset_value(input int idx);
    return 16'hC300 + DATA_W'(idx);
  endfunction

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int PRE_MIN  = 32,
  parameter int NUM_REGS = 8,
  parameter int CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  output mdio_state_e       state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output mdio_req_t         req_o,
  output logic              ta_ok_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ta0_o,
  output logic              ta1_o,
  output logic              shift_o,
  output logic              fin_o
);

  localparam logic [CNT_W-1:0] PRE_SAT  = CNT_W'(PRE_MIN);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  mdio_state_e         state;
  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hdr;
  logic [HDR_BITS-1:0] hdr_next;
  logic [DATA_W-2:0]   dsh;
  logic                ta_first;
  logic                ta_ok;
  mdio_req_t           req;
  mdio_req_t           req_next;

  assign hdr_next = {hdr[HDR_BITS-2:0], mdio_i};

  // Decode the header as the last register-address bit arrives.
  always_comb begin
    logic [1:0]        op;
    logic [ADDR_W-1:0] dev;
    op                = hdr_next[HDR_BITS-1 -: 2];
    dev               = hdr_next[2*ADDR_W-1 -: ADDR_W];
    req_next.reg_addr = hdr_next[ADDR_W-1:0];
    req_next.rd       = (dev == phy_addr_i) && (op == OP_READ);
    req_next.wr       = (dev == phy_addr_i) && (op == OP_WRITE);
    req_next.hit      = int'(hdr_next[ADDR_W-1:0]) < NUM_REGS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      hdr      <= '0;
      dsh      <= '0;
      ta_first <= 1'b0;
      ta_ok    <= 1'b0;
      req      <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (mdio_i) begin
            if (cnt != PRE_SAT) cnt <= cnt + 1'b1;
          end else if (cnt == PRE_SAT) begin
            state <= ST_START;
            cnt   <= '0;
          end else begin
            cnt <= '0;
          end
        end
        ST_START: begin
          cnt   <= '0;
          state <= mdio_i ? ST_HDR : ST_HUNT;
        end
        ST_HDR: begin
          hdr <= hdr_next;
          if (cnt == HDR_LAST) begin
            state <= ST_TA;
            cnt   <= '0;
            req   <= req_next;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TA: begin
          if (cnt == '0) begin
            ta_first <= mdio_i;
            cnt      <= cnt + 1'b1;
          end else begin
            ta_ok <= ta_first & ~mdio_i;
            state <= ST_DATA;
            cnt   <= '0;
          end
        end
        ST_DATA: begin
          dsh <= {dsh[DATA_W-3:0], mdio_i};
          if (cnt == DAT_LAST) begin
            state <= ST_HUNT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_HUNT;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign state_o   = state;
  assign cnt_o     = cnt;
  assign req_o     = req;
  assign ta_ok_o   = ta_ok;
  assign ta0_o     = (state == ST_TA) && (cnt == '0);
  assign ta1_o     = (state == ST_TA) && (cnt != '0);
  assign shift_o   = (state == ST_DATA) && (cnt != DAT_LAST);
  assign fin_o     = (state == ST_DATA) && (cnt == DAT_LAST);
  assign wr_data_o = {dsh, mdio_i};
  assign wr_en_o   = fin_o && req.wr && req.hit && ta_ok;

  // Start is entered only from a hunt with a full preamble and a zero bit.
  AST_START_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> ($past(state) == ST_HUNT && $past(cnt) == PRE_SAT && !$past(mdio_i))); // R1

  AST_HDR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR) |-> (cnt <= HDR_LAST)); // R3

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= reg_reset_value(g);
      else if (we && waddr == ADDR_W'(g))
        regs[g] <= wdata;
    end
  end

  // Registered read; unimplemented addresses return all ones.
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '1;
    else if (int'(raddr) < NUM_REGS)
      rdata <= regs[raddr[IDX_W-1:0]];
    else
      rdata <= '1;
  end

  AST_WRITE_IMPLEMENTED_ONLY: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < NUM_REGS)); // R8

endmodule

// File: rtl/mdio_tx.sv
module mdio_tx
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ta0,
  input  logic              ta1,
  input  logic              shift,
  input  logic              fin,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);

  logic [DATA_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
      sh      <= '0;
    end else if (ta0) begin
      mdio_oe <= rd_en;
      mdio_o  <= 1'b0;
    end else if (ta1) begin
      mdio_o <= mdio_oe & rdata[DATA_W-1];
      sh     <= rdata[DATA_W-2:0];
    end else if (shift) begin
      mdio_o <= mdio_oe & sh[DATA_W-2];
      sh     <= {sh[DATA_W-3:0], 1'b0};
    end else if (fin) begin
      mdio_oe <= 1'b0;
      mdio_o  <= 1'b0;
    end
  end

  AST_RELEASE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    fin |=> !mdio_oe); // R9

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PRE_MIN  = 32
) (
  input  logic        mdc,
  input  logic        rst,
  input  logic [4:0]  phy_addr_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  localparam int CNT_MAX = (PRE_MIN > DATA_W) ? PRE_MIN : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mdio_state_e       state;
  logic [CNT_W-1:0]  cnt;
  mdio_req_t         req;
  logic              ta_ok;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rdata;
  logic              ta0, ta1, shift, fin;

  mdio_frame_fsm #(
    .PRE_MIN (PRE_MIN),
    .NUM_REGS(NUM_REGS),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (mdc),
    .rst       (rst),
    .mdio_i    (mdio_i),
    .phy_addr_i(phy_addr_i),
    .state_o   (state),
    .cnt_o     (cnt),
    .req_o     (req),
    .ta_ok_o   (ta_ok),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .ta0_o     (ta0),
    .ta1_o     (ta1),
    .shift_o   (shift),
    .fin_o     (fin)
  );

  mdio_regfile #(
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk  (mdc),
    .rst  (rst),
    .we   (wr_en),
    .waddr(req.reg_addr),
    .wdata(wr_data),
    .raddr(req.reg_addr),
    .rdata(rdata)
  );

  mdio_tx u_tx (
    .clk    (mdc),
    .rst    (rst),
    .ta0    (ta0),
    .ta1    (ta1),
    .shift  (shift),
    .fin    (fin),
    .rd_en  (req.rd),
    .rdata  (rdata),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

  AST_TA_FIRST_HIZ: assert property (@(posedge mdc) disable iff (rst)
    (state == ST_TA && cnt == '0) |-> !mdio_oe); // R4

  AST_TA_SECOND_LOW: assert property (@(posedge mdc) disable iff (rst)
    (state == ST_TA && cnt != '0 && mdio_oe) |-> !mdio_o); // R4

  AST_OE_WINDOW: assert property (@(posedge mdc) disable iff (rst)
    mdio_oe |-> ((state == ST_TA && cnt != '0) || state == ST_DATA)); // R9

  AST_OE_OWN_READ: assert property (@(posedge mdc) disable iff (rst)
    mdio_oe |-> req.rd); // R3

  AST_WRITE_NEEDS_TA: assert property (@(posedge mdc) disable iff (rst)
    wr_en |-> (ta_ok && req.wr && state == ST_DATA)); // R6

  AST_BACK_TO_BACK: assert property (@(posedge mdc) disable iff (rst)
    fin |=> (state == ST_HUNT && cnt == '0)); // R10

endmodule

// File: tb/tb_mdio_slave.sv
module tb_mdio_slave;

  localparam int         NUM_REGS = 8;
  localparam logic [4:0] MY_PHY   = 5'h0B;

  logic       mdc = 1'b0;
  logic       rst;
  logic [4:0] phy_addr_i;
  logic       mdio_i;
  logic       mdio_o;
  logic       mdio_oe;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] model [32];

  always #4 mdc = ~mdc;

  mdio_slave #(.NUM_REGS(NUM_REGS), .PRE_MIN(32)) dut (
    .mdc       (mdc),
    .rst       (rst),
    .phy_addr_i(phy_addr_i),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  function automatic logic [15:0] rst_val(input int i);
    return 16'hC300 + 16'(i);
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] ra);
    return (int'(ra) < NUM_REGS) ? model[ra] : 16'hFFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One frame from the station; pre = number of preamble ones.
  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] wd,
                       input string tag);
    logic [31:0] fld;
    logic [15:0] got;
    logic [15:0] exp_d;
    int          oe_err;
    bit          synced, is_rd, is_wr;
    fld    = {2'b01, op, phy, ra, ta, wd};
    got    = '0;
    oe_err = 0;
    synced = (pre >= 32);
    is_rd  = synced && op == 2'b10 && phy == MY_PHY;
    is_wr  = synced && op == 2'b01 && phy == MY_PHY && int'(ra) < NUM_REGS && ta == 2'b10;
    exp_d  = exp_read(ra);
    for (int i = 0; i < pre + 32; i++) begin
      logic exp_oe;
      @(negedge mdc);
      exp_oe = is_rd && (i >= pre + 15);
      if (mdio_oe !== exp_oe) oe_err++;
      if (exp_oe && i == pre + 15 && mdio_o !== 1'b0) oe_err++;
      if (exp_oe && i >= pre + 16) got[15 - (i - pre - 16)] = mdio_o;
      mdio_i = (i < pre) ? 1'b1 : fld[31 - (i - pre)];
    end
    check({tag, " R4 R9 output-enable window"}, oe_err, 0);
    if (is_rd) check({tag, " R5 read data"}, {16'h0, got}, {16'h0, exp_d});
    if (is_wr) model[ra] = wd;
  endtask

  task automatic idle_check(input int n, input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge mdc);
      if (mdio_oe !== 1'b0) bad++;
      mdio_i = 1'b1;
    end
    check(tag, bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    phy_addr_i = MY_PHY;
    mdio_i     = 1'b1;
    rst        = 1'b1;
    for (int i = 0; i < 32; i++) model[i] = rst_val(i);
    repeat (3) @(negedge mdc);
    check("R11 oe low in reset", {31'h0, mdio_oe}, 0);
    rst = 1'b0;
    idle_check(4, "R11 oe low after reset");

    // Reset values, read path (R11, R4, R5)
    frame(32, 2'b10, MY_PHY, 5'd0, 2'b11, 16'hFFFF, "R11 reset value reg0");
    frame(35, 2'b10, MY_PHY, 5'd5, 2'b11, 16'hFFFF, "R11 reset value reg5");

    // Write and read back (R6)
    frame(32, 2'b01, MY_PHY, 5'd3, 2'b10, 16'hA5C3, "R6 write reg3");
    frame(32, 2'b10, MY_PHY, 5'd3, 2'b11, 16'h0000, "R6 readback reg3");
    // Bad turnaround on write: no store
    frame(32, 2'b01, MY_PHY, 5'd3, 2'b11, 16'h1111, "R6 bad TA write");
    frame(32, 2'b10, MY_PHY, 5'd3, 2'b11, 16'h0000, "R6 reg3 unchanged after bad TA");

    // Unimplemented register (R7, R8)
    frame(32, 2'b01, MY_PHY, 5'd20, 2'b10, 16'h1234, "R8 write unimplemented");
    frame(32, 2'b10, MY_PHY, 5'd20, 2'b11, 16'h0000, "R7 read unimplemented");
    frame(32, 2'b10, MY_PHY, 5'd31, 2'b11, 16'h0000, "R7 read top address");
    for (int r = 0; r < NUM_REGS; r++)
      frame(32, 2'b10, MY_PHY, 5'(r), 2'b11, 16'h0000, "R8 implemented regs intact");

    // Foreign device address (R3)
    frame(32, 2'b01, MY_PHY ^ 5'h01, 5'd2, 2'b10, 16'hDEAD, "R3 foreign write");
    frame(32, 2'b10, MY_PHY ^ 5'h10, 5'd2, 2'b11, 16'h0000, "R3 foreign read quiet");
    frame(32, 2'b10, MY_PHY, 5'd2, 2'b11, 16'h0000, "R3 reg2 unchanged");

    // Unused opcodes (R2)
    frame(32, 2'b11, MY_PHY, 5'd1, 2'b10, 16'hBEEF, "R2 opcode 11");
    frame(32, 2'b00, MY_PHY, 5'd1, 2'b10, 16'hCAFE, "R2 opcode 00");
    frame(32, 2'b10, MY_PHY, 5'd1, 2'b11, 16'h0000, "R2 reg1 unchanged");

    // Short preamble (R1), immediately after a completed frame
    frame(31, 2'b01, MY_PHY, 5'd6, 2'b10, 16'h0F0F, "R1 short preamble write");
    frame(32, 2'b10, MY_PHY, 5'd6, 2'b11, 16'h0000, "R1 reg6 unchanged");

    // Back-to-back with minimum preamble (R10)
    frame(32, 2'b01, MY_PHY, 5'd7, 2'b10, 16'h8001, "R10 back-to-back write");
    frame(32, 2'b10, MY_PHY, 5'd7, 2'b11, 16'h0000, "R10 back-to-back read");
    frame(32, 2'b10, MY_PHY, 5'd0, 2'b11, 16'h0000, "R10 back-to-back read again");

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      logic [4:0] phy;
      logic [4:0] ra;
      logic [1:0] ta;
      int         sel;
      sel = int'($urandom % 16);
      op  = (sel < 7) ? 2'b10 : (sel < 14) ? 2'b01 : 2'(sel);
      phy = ($urandom % 5 == 0) ? 5'($urandom) : MY_PHY;
      ra  = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % NUM_REGS);
      ta  = ($urandom % 6 == 0) ? 2'($urandom) : 2'b10;
      frame(32 + int'($urandom % 3), op, phy, ra, ta, 16'($urandom), "R2 R3 R6 R10 random");
    end

    for (int r = 0; r < NUM_REGS; r++)
      frame(32, 2'b10, MY_PHY, 5'(r), 2'b11, 16'h0000, "R6 final register sweep");
    idle_check(8, "R9 line released when idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule